// File: doc/BRIEF.md
# Burst Column Address Generator

This block turns one read or write command into the stream of column addresses that a synchronous DRAM burst walks through inside a row of 2^COL_W columns. A start strobe loads the starting column, a burst-length code, the ordering (linear or interleaved) and the access direction. From the next clock on, the block presents one column per cycle with a beat-valid flag, and it marks the final beat. A downstream command sequencer consumes these beats. The block never drives the memory command bus itself.

A linear burst counts upward through the low bits selected by the length and wraps inside that aligned group. An interleaved burst XORs the beat index into those bits. The full-page length visits every column of the row, always in linear order, and wraps from the top column to column zero. A stop input cuts the burst short. A single-write mode bit limits write commands to one beat and leaves reads at the programmed length.

Top module: `burst_col_gen`

## Requirements
- R1: After reset, `beat_o`, `last_o` and `busy_o` are low.
- R2: The beat in the cycle after `start_i` is high carries the column given on `start_col_i`.
- R3: `len_code_i` selects the length as follows: 0 gives 1 beat, 1 gives 2, 2 gives 4, 3 gives 8, and 7 gives full page (256 beats with COL_W=8). Codes 4 to 6 give 1 beat.
- R4: In a linear burst of length L (2, 4 or 8), beat i has the start column's upper bits unchanged, and its low log2(L) bits equal (start + i) mod L.
- R5: In an interleaved burst of length L (2, 4 or 8), beat i carries the start column XOR i.
- R6: A full-page burst is linear even when `interleave_i` is 1. Beat i carries (start + i) mod 2^COL_W, so the columns wrap from the top column to 0.
- R7: `last_o` is high only together with the final beat of a burst that runs to its full length.
- R8: If `stop_i` is high during a beat, that beat is the final one: no beat follows in the next cycle unless a new start was given.
- R9: When `wr_i` and `single_wr_i` are both 1 at the start, the burst has exactly 1 beat. Reads (`wr_i`=0) use the programmed length whatever `single_wr_i` is.
- R10: A start strobe during a running burst abandons it. The next cycle carries beat 0 of the new burst.
- R11: `busy_o` is high in every cycle where `start_i` or `beat_o` is high, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe for a new burst |
| start_col_i | input | COL_W | First column of the burst |
| len_code_i | input | 3 | Burst-length code (see R3) |
| interleave_i | input | 1 | 1 = interleaved order, 0 = linear |
| wr_i | input | 1 | 1 = write command, 0 = read |
| single_wr_i | input | 1 | Single-beat write mode bit |
| stop_i | input | 1 | Ends the running burst after this beat |
| col_o | output | COL_W | Column address of the current beat |
| beat_o | output | 1 | A beat is present this cycle |
| last_o | output | 1 | Current beat is the final one |
| busy_o | output | 1 | Start strobe or beat in this cycle |

## Verification
The bench builds the block with the default COL_W of 8, so the full row is exactly 256 columns. With that width it can run every starting column under both orderings for lengths 2, 4 and 8 and compare each beat to an arithmetic model. Full-page bursts starting near the top of the row exercise the 255-to-0 wrap and the 256-beat end. Directed runs add the reserved length codes, stops at several beat positions, restarts part-way through a burst, and every combination of the direction bit and the single-write bit.

// File: rtl/bcg_pkg.sv
package bcg_pkg;
    typedef enum logic [2:0] {
        BLEN_1    = 3'd0,
        BLEN_2    = 3'd1,
        BLEN_4    = 3'd2,
        BLEN_8    = 3'd3,
        BLEN_PAGE = 3'd7
    } blen_code_e;
endpackage

// File: rtl/bcg_len_decode.sv
module bcg_len_decode
    import bcg_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic [2:0]       code_i,
    input  logic             force_one_i,
    output logic [COL_W-1:0] mask_o,
    output logic             page_o
);
    localparam logic [COL_W-1:0] PAGE_MASK = {COL_W{1'b1}};

    always_comb begin
        mask_o = '0;
        page_o = 1'b0;
        if (!force_one_i) begin
            case (code_i)
                BLEN_2:    mask_o = COL_W'(1);
                BLEN_4:    mask_o = COL_W'(3);
                BLEN_8:    mask_o = COL_W'(7);
                BLEN_PAGE: begin
                    mask_o = PAGE_MASK;
                    page_o = 1'b1;
                end
                default:   mask_o = '0;
            endcase
        end
    end
endmodule

// File: rtl/bcg_col_map.sv
module bcg_col_map #(
    parameter int COL_W = 8
) (
    input  logic [COL_W-1:0] base_i,
    input  logic [COL_W-1:0] idx_i,
    input  logic [COL_W-1:0] mask_i,
    input  logic             inter_i,
    output logic [COL_W-1:0] col_o
);
    logic [COL_W-1:0] sum;

    always_comb begin
        sum = base_i + idx_i;
        if (inter_i) col_o = base_i ^ (idx_i & mask_i);
        else         col_o = (base_i & ~mask_i) | (sum & mask_i);
    end
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen #(
    parameter int COL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [COL_W-1:0] start_col_i,
    input  logic [2:0]       len_code_i,
    input  logic             interleave_i,
    input  logic             wr_i,
    input  logic             single_wr_i,
    input  logic             stop_i,
    output logic [COL_W-1:0] col_o,
    output logic             beat_o,
    output logic             last_o,
    output logic             busy_o
);
    typedef struct packed {
        logic             active;
        logic             inter;
        logic [COL_W-1:0] base;
        logic [COL_W-1:0] mask;
        logic [COL_W-1:0] idx;
    } burst_state_t;

    burst_state_t st_d, st_q;

    logic [COL_W-1:0] dec_mask;
    logic             dec_page;
    logic             final_beat;

    bcg_len_decode #(.COL_W(COL_W)) u_dec (
        .code_i      (len_code_i),
        .force_one_i (wr_i & single_wr_i),
        .mask_o      (dec_mask),
        .page_o      (dec_page)
    );

    bcg_col_map #(.COL_W(COL_W)) u_map (
        .base_i  (st_q.base),
        .idx_i   (st_q.idx),
        .mask_i  (st_q.mask),
        .inter_i (st_q.inter),
        .col_o   (col_o)
    );

    assign final_beat = st_q.active && (st_q.idx == st_q.mask);
    assign beat_o     = st_q.active;
    assign last_o     = final_beat;
    assign busy_o     = start_i | st_q.active;

    always_comb begin
        st_d = st_q;
        if (start_i) begin
            st_d.active = 1'b1;
            st_d.inter  = interleave_i & ~dec_page;
            st_d.base   = start_col_i;
            st_d.mask   = dec_mask;
            st_d.idx    = '0;
        end else if (st_q.active) begin
            if (stop_i || final_beat) st_d.active = 1'b0;
            else                      st_d.idx    = st_q.idx + COL_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/burst_col_gen_chk.sv
module burst_col_gen_chk #(
    parameter int COL_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic [COL_W-1:0] start_col_i,
    input logic             wr_i,
    input logic             single_wr_i,
    input logic             stop_i,
    input logic [COL_W-1:0] col_o,
    input logic             beat_o,
    input logic             last_o,
    input logic             busy_o
);
    assert_start_col_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (beat_o && col_o == $past(start_col_i)));

    assert_last_with_beat_R7: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |-> beat_o);

    assert_end_after_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (last_o && !start_i) |=> !beat_o);

    assert_stop_ends_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_o && stop_i && !start_i) |=> !beat_o);

    assert_continue_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_o && !last_o && !stop_i) |=> beat_o);

    assert_single_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && wr_i && single_wr_i) |=> last_o);

    assert_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o == (start_i || beat_o));
endmodule

bind burst_col_gen burst_col_gen_chk #(.COL_W(COL_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .start_col_i (start_col_i),
    .wr_i        (wr_i),
    .single_wr_i (single_wr_i),
    .stop_i      (stop_i),
    .col_o       (col_o),
    .beat_o      (beat_o),
    .last_o      (last_o),
    .busy_o      (busy_o)
);

// File: tb/tb_burst_col_gen.sv
module tb_burst_col_gen;
    localparam int CLK_PERIOD = 10;
    localparam int COL_W      = 8;
    localparam int ROW        = 1 << COL_W;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic [COL_W-1:0] start_col_i = '0;
    logic [2:0]       len_code_i = '0;
    logic             interleave_i = 1'b0;
    logic             wr_i = 1'b0;
    logic             single_wr_i = 1'b0;
    logic             stop_i = 1'b0;
    logic [COL_W-1:0] col_o;
    logic             beat_o, last_o, busy_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    burst_col_gen #(.COL_W(COL_W)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_col_i(start_col_i),
        .len_code_i(len_code_i), .interleave_i(interleave_i), .wr_i(wr_i),
        .single_wr_i(single_wr_i), .stop_i(stop_i), .col_o(col_o),
        .beat_o(beat_o), .last_o(last_o), .busy_o(busy_o)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int len_of(input int code, input bit wr, input bit sw);
        if (wr && sw) return 1;
        case (code)
            1: return 2;
            2: return 4;
            3: return 8;
            7: return ROW;
            default: return 1;
        endcase
    endfunction

    function automatic int exp_col(input int sc, input int len, input bit il, input int i);
        int m = len - 1;
        if (il && len != ROW) return sc ^ i;
        return (sc & ~m & (ROW-1)) | ((sc + i) & m);
    endfunction

    task automatic kick(input int sc, input int code, input bit il, input bit wr, input bit sw);
        @(negedge clk);
        start_i = 1'b1; start_col_i = COL_W'(sc); len_code_i = 3'(code);
        interleave_i = il; wr_i = wr; single_wr_i = sw;
        #1 check("R11", "busy on strobe", int'(busy_o), 1);
        @(negedge clk);
        start_i = 1'b0;
    endtask

    // Runs one burst; stop_at < 0 means no stop.
    task automatic burst(input string req, input int sc, input int code, input bit il,
                         input bit wr, input bit sw, input int stop_at);
        int len = len_of(code, wr, sw);
        int nb  = (stop_at >= 0 && stop_at < len) ? stop_at + 1 : len;
        kick(sc, code, il, wr, sw);
        for (int i = 0; i < nb; i++) begin
            check(req, "beat", int'(beat_o), 1);
            check(req, "col", int'(col_o), exp_col(sc, len, il, i));
            check("R7", "last", int'(last_o), (i == len-1) ? 1 : 0);
            if (i == stop_at) stop_i = 1'b1;
            @(negedge clk);
            stop_i = 1'b0;
        end
        check(req, "idle after burst", int'(beat_o), 0);
        check("R11", "busy idle", int'(busy_o), 0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1", "beat after reset", int'(beat_o), 0);
        check("R1", "last after reset", int'(last_o), 0);
        check("R1", "busy after reset", int'(busy_o), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 R4 R5: every start column, lengths 2/4/8, both orders
        for (int code = 1; code <= 3; code++)
            for (int il = 0; il < 2; il++)
                for (int sc = 0; sc < ROW; sc++)
                    burst(il ? "R5" : "R4", sc, code, bit'(il), 1'b0, 1'b0, -1);

        // R3: length 1 and reserved codes
        for (int code = 0; code <= 6; code++)
            if (code == 0 || code >= 4) burst("R3", 37, code, 1'b0, 1'b0, 1'b0, -1);

        // R6: full page, wrap, interleave ignored
        burst("R6", 250, 7, 1'b0, 1'b0, 1'b0, -1);
        burst("R6", 255, 7, 1'b1, 1'b0, 1'b0, -1);
        burst("R6", 0, 7, 1'b1, 1'b0, 1'b0, -1);

        // R8: stops at several beats
        burst("R8", 13, 3, 1'b0, 1'b0, 1'b0, 0);
        burst("R8", 13, 3, 1'b1, 1'b0, 1'b0, 4);
        burst("R8", 200, 7, 1'b0, 1'b0, 1'b0, 70);
        burst("R8", 9, 2, 1'b0, 1'b0, 1'b0, 3);

        // R9: single-write mode
        burst("R9", 21, 3, 1'b0, 1'b1, 1'b1, -1);
        burst("R9", 21, 7, 1'b1, 1'b1, 1'b1, -1);
        burst("R9", 21, 3, 1'b0, 1'b0, 1'b1, -1);
        burst("R9", 21, 2, 1'b1, 1'b1, 1'b0, -1);

        // R10: restart during a running burst
        kick(5, 3, 1'b0, 1'b0, 1'b0);
        check("R10", "first col", int'(col_o), 5);
        @(negedge clk);
        check("R10", "second col", int'(col_o), 6);
        start_i = 1'b1; start_col_i = 8'd42; len_code_i = 3'd2; interleave_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        for (int i = 0; i < 4; i++) begin
            check("R10", "beat", int'(beat_o), 1);
            check("R10", "col", int'(col_o), 42 ^ i);
            check("R10", "last", int'(last_o), (i == 3) ? 1 : 0);
            @(negedge clk);
        end
        check("R10", "idle", int'(beat_o), 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule